// File: doc/BRIEF.md
# Write Completion Status Word Generator

This block sits on the read path between the memory array and the output data bus of a flash-style device. While an internal program or erase is in progress, a read of the array would return meaningless data, so the block substitutes a status word. Bit 7 is a polling bit: during a program it is the inverse of bit 7 of the word being written, and during an erase it reads 0. Bit 6 is a toggle bit that inverts on every read strobe while the operation runs. A host polls either bit to find out when the operation has finished.

When the busy flag drops, bit 7 switches to true array data at once. The other bits stay on status values for a settle window of `SETTLE` clocks, modelling the interval in which only bit 7 is guaranteed valid. After the window the full array word passes through unchanged. The status word appears in the same cycle that busy rises, which is the cycle of the final write of the command sequence. The toggle bit restarts from 0 at the start of each operation.

Top module: `wstat_gen`

## Requirements
- R1: While `busy` is 1 and `op_erase` is 0 (program), `rd_data[7]` equals the inverse of `prog_data[7]`.
- R2: While `busy` is 1 and `op_erase` is 1 (erase), `rd_data[7]` is 0. Once busy drops, bit 7 follows `arr_data[7]`, which reads 1 for an erased word.
- R3: While busy, `rd_data[6]` inverts in the cycle after each cycle in which `rd_stb` is 1. In a cycle after one without a strobe it holds its value.
- R4: In the first busy cycle of each operation, `rd_data[6]` reads 0 whatever value the toggle had at the end of the previous operation.
- R5: The status word replaces array data combinationally, in the same cycle in which `busy` rises. No cycle of delay is added.
- R6: For `SETTLE` clocks starting with the first cycle in which `busy` is 0, `rd_data[7]` equals `arr_data[7]`, `rd_data[6]` holds the final toggle value and the remaining bits read 0.
- R7: Once the settle window has expired and `busy` is 0, `rd_data` equals `arr_data` in all bits.
- R8: While busy, every bit other than bits 7 and 6 reads 0.
- R9: After reset, with `busy` 0, `rd_data` equals `arr_data`.
- R10: If `busy` rises again during a settle window, the status word returns in that same cycle and the toggle bit restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Internal program or erase is running |
| op_erase | input | 1 | 1 for erase, 0 for program; held for the whole operation |
| prog_data | input | DW | Word being programmed; held for the whole operation |
| rd_stb | input | 1 | One read access in this cycle |
| arr_data | input | DW | True data from the array |
| rd_data | output | DW | Word presented to the output bus |

## Verification
A toggle register that fails to clear at the start of an operation shows as bit 6 reading 1 on the first busy cycle. A toggle register that advances on clocks instead of strobes breaks the hold check one cycle after a quiet cycle. A settle counter that is loaded with the wrong value shows as a pass-through that comes one cycle too early or too late at the end of the window. Because the bench compares every cycle, any of these faults is reported within one or two clocks of the event that exposes it.

// File: rtl/wstat_gen.sv
module wstat_gen #(
  parameter int DW     = 16,
  parameter int SETTLE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          op_erase,
  input  logic [DW-1:0] prog_data,
  input  logic          rd_stb,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data
);
  localparam int POLL = 7;
  localparam int TGL  = 6;
  localparam int SW   = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [SW-1:0] LOAD = SW'(SETTLE - 1);

  logic          busy_q;
  logic          tog;
  logic [SW-1:0] cnt;

  wire start  = busy & ~busy_q;
  wire falls  = ~busy & busy_q;
  wire win    = (SETTLE > 0) && (falls || cnt != '0);
  wire tog_rd = start ? 1'b0 : tog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tog    <= 1'b0;
      cnt    <= '0;
    end else begin
      busy_q <= busy;
      if (start)             tog <= rd_stb;
      else if (busy && rd_stb) tog <= ~tog;
      if (busy)              cnt <= '0;
      else if (falls)        cnt <= LOAD;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    rd_data = arr_data;
    if (busy) begin
      rd_data       = '0;
      rd_data[POLL] = op_erase ? 1'b0 : ~prog_data[POLL];
      rd_data[TGL]  = tog_rd;
    end else if (win) begin
      rd_data       = '0;
      rd_data[POLL] = arr_data[POLL];
      rd_data[TGL]  = tog;
    end
  end

  a_r1_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !op_erase |-> rd_data[POLL] == ~prog_data[POLL]);
  a_r2_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_erase |-> rd_data[POLL] == 1'b0);
  a_r3_tog_flip: assert property (@(posedge clk) disable iff (!rst_n)
    busy && busy_q && rd_stb |=> (!busy || rd_data[TGL] != $past(rd_data[TGL])));
  a_r3_tog_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && busy_q && !rd_stb |=> (!busy || rd_data[TGL] == $past(rd_data[TGL])));
  a_r4_tog_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !busy_q |-> rd_data[TGL] == 1'b0);
  a_r6_true_poll: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rd_data[POLL] == arr_data[POLL]);
  a_r8_mask: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rd_data[TGL-1:0] == '0);
endmodule

// File: tb/wstat_gen_bench.sv
module wstat_gen_bench;
  localparam int DW = 16;
  localparam int SETTLE = 4;

  logic clk = 0, rst_n = 0, busy = 0, op_erase = 0, rd_stb = 0;
  logic [DW-1:0] prog_data = '0, arr_data = '0, rd_data;
  int n_run = 0, n_fail = 0;
  bit m_bq = 0, m_tog = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  wstat_gen #(.DW(DW), .SETTLE(SETTLE)) u_wstat_gen (
    .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
    .prog_data(prog_data), .rd_stb(rd_stb), .arr_data(arr_data), .rd_data(rd_data));

  function automatic logic [DW-1:0] expect_word(bit b, bit e, logic [DW-1:0] p, logic [DW-1:0] a);
    logic [DW-1:0] w;
    bit st = b && !m_bq;
    bit win = (m_bq && !b) || (m_cnt > 0);
    if (b) begin
      w = '0; w[7] = e ? 1'b0 : ~p[7]; w[6] = st ? 1'b0 : m_tog;
    end else if (win) begin
      w = '0; w[7] = a[7]; w[6] = m_tog;
    end else w = a;
    return w;
  endfunction

  function automatic string auto_tag(bit b, bit e);
    if (b) return (!m_bq) ? "R4" : (e ? "R2" : "R1");
    return ((m_bq) || (m_cnt > 0)) ? "R6" : "R7";
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit b, bit e, logic [DW-1:0] p, bit s, logic [DW-1:0] a, string tag);
    logic [DW-1:0] ex;
    busy = b; op_erase = e; prog_data = p; rd_stb = s; arr_data = a;
    #5;
    ex = expect_word(b, e, p, a);
    check(tag == "" ? auto_tag(b, e) : tag, rd_data, ex);
    @(posedge clk);
    if (b && !m_bq) m_tog = s;
    else if (b && s) m_tog = ~m_tog;
    if (b) m_cnt = 0;
    else if (m_bq) m_cnt = SETTLE - 1;
    else if (m_cnt > 0) m_cnt--;
    m_bq = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(0, 0, 0, 0, 16'h1234, "R9");
    cyc(0, 0, 0, 1, 16'hA5C3, "R9");
    // program of a word with bit 7 set
    cyc(1, 0, 16'h0080, 1, 16'hFFFF, "R5");
    cyc(1, 0, 16'h0080, 1, 16'hFFFF, "R3");
    cyc(1, 0, 16'h0080, 0, 16'hFFFF, "R3");
    cyc(1, 0, 16'h0080, 0, 16'hFFFF, "R3");
    cyc(1, 0, 16'h0080, 1, 16'hFFFF, "R1");
    cyc(1, 0, 16'h0080, 0, 16'hFFFF, "R8");
    for (int i = 0; i < SETTLE; i++) cyc(0, 0, 0, 1, 16'h7F3F, "R6");
    cyc(0, 0, 0, 0, 16'h7F3F, "R7");
    // erase, with toggle left at 1 before the next start
    cyc(1, 1, 16'h0000, 1, 16'h0000, "R4");
    cyc(1, 1, 16'h0000, 0, 16'h0000, "R2");
    cyc(1, 1, 16'h0000, 0, 16'h0000, "R8");
    cyc(0, 1, 16'h0000, 0, 16'hFFFF, "R2");
    cyc(0, 1, 16'h0000, 0, 16'hFFFF, "R6");
    // restart inside the settle window
    cyc(1, 0, 16'h0001, 0, 16'hFFFF, "R10");
    cyc(1, 0, 16'h0001, 1, 16'hFFFF, "R10");
    cyc(0, 0, 0, 0, 16'h00FF, "R6");
    for (int i = 0; i < SETTLE + 1; i++) cyc(0, 0, 0, 0, 16'hBEEF, "");
    // random operations
    for (int op = 0; op < 150; op++) begin
      bit e = $urandom_range(0, 1);
      logic [DW-1:0] p = DW'($urandom);
      int len = $urandom_range(1, 12);
      int gap = $urandom_range(0, 7);
      for (int k = 0; k < len; k++) cyc(1, e, p, $urandom_range(0, 1), DW'($urandom), "");
      for (int k = 0; k < gap; k++) cyc(0, e, p, $urandom_range(0, 1), DW'($urandom), "");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule